// File: doc/BRIEF.md
# Refresh-Counter Self-Test Sequencer

This block sits on the controller side of a 512-row dynamic memory. It checks the memory's internal refresh address counter by running a fixed test program at a single column. Data is written through cycles whose row comes from the counter, read back through cycles whose row the controller supplies, and then the reverse. After one `start` pulse the sequencer drives the row strobe, column strobe, write enable, output enable, address and data pins on its own. It compares every value it reads, keeps the first mismatch, and raises `done` when the test is over.

Each memory cycle has six phases. Every phase lasts `STEP_CLKS` clocks. A pin-level controller only has to meet the memory's nanosecond timing by choosing `STEP_CLKS`. The test runs two passes. The first pass uses the all-zeros value and then its inverse. The second pass uses the reversed data. Each pass has three stages: counter-addressed writes, then externally addressed read-and-invert, then counter-addressed reads.

Top module: `cbr_test_seq`

## Requirements
- R1: While reset is high and after it until `start`, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, `dq_oe`, `done`, `pass` and `fail` are 0.
- R2: A `start` first issues `INIT_CYC` (8) row-strobe-only cycles on rows 0 to 7 in order. During these `cas_n` stays high, and they come before any counter-addressed cycle.
- R3: In a counter-addressed cycle, `cas_n` is already low when `ras_n` falls. `cas_n` then rises and falls a second time. The data transfer happens at that second fall.
- R4: Every column strobe that falls while `ras_n` is low presents the parameter `COL` on `addr`.
- R5: Stage one issues 512 counter-addressed writes of the pass value. The pass value is all zeros in the first pass and all ones in the second.
- R6: Stage two visits rows 0 to 511 in ascending order. For each row it issues a normal read that expects the pass value, then a normal write of the inverted pass value to the same row.
- R7: Stage three issues 512 counter-addressed reads, each expecting the inverted pass value.
- R8: After the second pass (reversed data), `done` goes to 1 and all strobes are idle. `pass` is 1 exactly when `done` is 1 and no mismatch was seen.
- R9: The first mismatch sets the sticky `fail` and captures `fail_row` (the row index), `fail_phase` (1 = stage two normal read, 2 = stage three counter read) and `fail_pass` (0 = first pass, 1 = second). Later mismatches do not change these. A new `start` clears them.
- R10: `start` has no effect while a test is running. The sequence of memory cycles stays unchanged.
- R11: `dq_oe` is 1 only while `we_n` is low. `oe_n` is never low while `we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a test when idle or done |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| fail_row | output | AW | Row index of first mismatch |
| fail_phase | output | 2 | Stage of first mismatch (1 or 2) |
| fail_pass | output | 1 | Pass of first mismatch |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | AW | Multiplexed row/column address |
| dq_out | output | DW | Write data |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | DW | Read data from memory |

## Verification
The assertions assume that reset is held for at least two clocks, and that `dq_in` is settled by the last clock of the read phase, which follows the column strobe. The memory model in the bench reacts on the falling clock edge. It updates `dq_in` half a clock after the column strobe falls, and it drives `start` away from the rising edge, so every sampled input is stable. Faults are injected in the model only: a stuck data bit, a counter bit that is stuck high, and a one-time corrupted read. The sequencer's input timing stays the same in every run.

// File: rtl/cbr_test_seq.sv
module cbr_test_seq #(
  parameter int AW = 9,
  parameter int DW = 16,
  parameter int INIT_CYC = 8,
  parameter int STEP_CLKS = 2,
  parameter logic [AW-1:0] COL = 'h0A5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_row,
  output logic [1:0]    fail_phase,
  output logic          fail_pass,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  localparam int TW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [AW-1:0] INIT_LAST = AW'(INIT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_PA, S_PBR, S_PBW, S_PC, S_DONE} state_t;

  state_t        st;
  logic [2:0]    step;
  logic [TW-1:0] tick;
  logic [AW-1:0] idx;
  logic          second;

  wire running   = (st == S_INIT) || (st == S_PA) || (st == S_PBR) || (st == S_PBW) || (st == S_PC);
  wire ror_op    = (st == S_INIT);
  wire cbr_op    = (st == S_PA) || (st == S_PC);
  wire wr_op     = (st == S_PA) || (st == S_PBW);
  wire rd_op     = (st == S_PBR) || (st == S_PC);
  wire last_tick = (tick == TW'(STEP_CLKS - 1));
  wire end_op    = running && last_tick && (step == 3'd5);
  wire sample    = running && rd_op && last_tick && (step == 3'd4);
  wire row_win   = (step >= 3'd1) && (step <= 3'd4);
  wire dat_win   = (step >= 3'd2) && (step <= 3'd4);
  wire col_win   = (step == 3'd3) || (step == 3'd4);

  wire [DW-1:0] tv     = {DW{second}};
  wire [DW-1:0] exp_rd = (st == S_PC) ? ~tv : tv;

  assign done   = (st == S_DONE);
  assign pass   = done && !fail;
  assign ras_n  = !(running && row_win);
  assign cas_n  = !(running && !ror_op && (col_win || (cbr_op && step <= 3'd1)));
  assign we_n   = !(running && wr_op && dat_win);
  assign oe_n   = !(running && rd_op && col_win);
  assign dq_oe  = running && wr_op && dat_win;
  assign dq_out = dq_oe ? ((st == S_PA) ? tv : ~tv) : '0;
  assign addr   = !running ? '0 : (ror_op || (!cbr_op && step < 3'd2)) ? idx : COL;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      step       <= 3'd0;
      tick       <= '0;
      idx        <= '0;
      second     <= 1'b0;
      fail       <= 1'b0;
      fail_row   <= '0;
      fail_phase <= 2'd0;
      fail_pass  <= 1'b0;
    end else if (!running) begin
      if (start) begin
        st         <= S_INIT;
        step       <= 3'd0;
        tick       <= '0;
        idx        <= '0;
        second     <= 1'b0;
        fail       <= 1'b0;
        fail_row   <= '0;
        fail_phase <= 2'd0;
        fail_pass  <= 1'b0;
      end
    end else begin
      tick <= last_tick ? '0 : tick + TW'(1);
      if (last_tick) step <= (step == 3'd5) ? 3'd0 : step + 3'd1;
      if (sample && (dq_in != exp_rd) && !fail) begin
        fail       <= 1'b1;
        fail_row   <= idx;
        fail_phase <= (st == S_PC) ? 2'd2 : 2'd1;
        fail_pass  <= second;
      end
      if (end_op) begin
        case (st)
          S_INIT: begin
            idx <= (idx == INIT_LAST) ? '0 : idx + AW'(1);
            if (idx == INIT_LAST) st <= S_PA;
          end
          S_PA: begin
            idx <= idx + AW'(1);
            if (&idx) st <= S_PBR;
          end
          S_PBR: st <= S_PBW;
          S_PBW: begin
            idx <= idx + AW'(1);
            st  <= (&idx) ? S_PC : S_PBR;
          end
          S_PC: begin
            idx <= idx + AW'(1);
            if (&idx) begin
              if (second) st <= S_DONE;
              else begin
                second <= 1'b1;
                st     <= S_PA;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  cas_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cbr_op) |-> !cas_n);

  // R2
  ras_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && ror_op) |-> cas_n);

  // R11
  drive_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!we_n && oe_n));

  // R11
  we_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && running) |=> (fail && $stable(fail_row) && $stable(fail_phase) && $stable(fail_pass)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (running && start && !end_op) |=> ($stable(st) && $stable(idx)));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_PBR && end_op) |=> (st == S_PBW && $stable(idx)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ras_n && cas_n && we_n && oe_n && !dq_oe));

endmodule

// File: tb/cbr_test_seq_test.sv
module cbr_test_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] TCOL = 9'h0A5;

  typedef struct {
    int          kind;
    int          row;
    logic [15:0] data;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, pass, fail, fail_pass, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [8:0] fail_row, addr;
  logic [1:0] fail_phase;
  logic [15:0] dq_out;
  logic [15:0] dq_in = 16'hDEAD;

  cbr_test_seq #(.AW(9), .DW(16), .INIT_CYC(8), .STEP_CLKS(1), .COL(TCOL)) uut (
    .clk(clk), .rst(rst), .start(start), .done(done), .pass(pass), .fail(fail),
    .fail_row(fail_row), .fail_phase(fail_phase), .fail_pass(fail_pass),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  item_t sbq[$];

  logic [15:0] mem [512];
  int   ctr, fault, rd200, col_err, bus_err, ror_cnt;
  int   cur_row;
  bit   cyc_cbr, col_done, pr_ras = 1, pr_cas = 1;
  logic [15:0] rdata;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic observe(input int kind, input int row, input logic [15:0] d);
    item_t e;
    bit ok;
    if (sbq.size() == 0) begin
      chk(0, "R10 unexpected extra memory cycle", kind, -1);
      return;
    end
    e = sbq.pop_front();
    ok = (e.kind == kind);
    if (!(fault == 2 && (kind == 1 || kind == 4))) ok = ok && (e.row == row);
    if (kind == 1 || kind == 2) ok = ok && (e.data == d);
    chk(ok, e.tag, {kind[7:0], row[15:0], d}, {e.kind[7:0], e.row[15:0], e.data});
  endtask

  task automatic push(input int kind, input int row, input logic [15:0] d, input string tag);
    item_t e;
    e.kind = kind; e.row = row; e.data = d; e.tag = tag;
    sbq.push_back(e);
  endtask

  // Driver: expected cycle order. kinds: 0 row-only, 1 counter write, 2 normal write, 3 normal read, 4 counter read
  task automatic build_expect();
    sbq.delete();
    for (int r = 0; r < 8; r++) push(0, r, 16'h0, "R2 init row-only cycle");
    for (int p = 0; p < 2; p++) begin
      logic [15:0] tv;
      tv = (p == 1) ? 16'hFFFF : 16'h0000;
      for (int i = 0; i < 512; i++) push(1, i, tv, p ? "R8 R5 counter write" : "R5 counter write");
      for (int i = 0; i < 512; i++) begin
        push(3, i, 16'h0, "R6 normal read");
        push(2, i, ~tv, p ? "R8 R6 normal write" : "R6 normal write");
      end
      for (int i = 0; i < 512; i++) push(4, i, 16'h0, "R7 counter read");
    end
  endtask

  task automatic model_reset(input int f);
    for (int i = 0; i < 512; i++) mem[i] = 16'h5A5A;
    ctr = 0; fault = f; rd200 = 0; col_err = 0; bus_err = 0; ror_cnt = 0;
  endtask

  // Memory model and monitor, active on the falling clock edge
  always @(negedge clk) begin
    if (!rst) begin
      if (pr_ras && !ras_n) begin
        col_done = 0;
        if (!cas_n) begin
          cyc_cbr = 1;
          cur_row = (fault == 2) ? (ctr | 16) : ctr;
          ctr = (ctr + 1) % 512;
        end else begin
          cyc_cbr = 0;
          cur_row = int'(addr);
        end
      end
      if (pr_cas && !cas_n && !ras_n) begin
        col_done = 1;
        if (addr != TCOL) col_err++;
        if (!we_n) begin
          mem[cur_row] = dq_out;
          observe(cyc_cbr ? 1 : 2, cur_row, dq_out);
        end else begin
          rdata = mem[cur_row];
          if (cur_row == 200) rd200++;
          if (fault == 1 && cur_row == 37) rdata[0] = 1'b0;
          if (fault == 3 && cur_row == 200 && rd200 == 3) rdata[3] = ~rdata[3];
          observe(cyc_cbr ? 4 : 3, cur_row, rdata);
        end
      end
      if (!pr_ras && ras_n && !col_done && !cyc_cbr) begin
        ror_cnt++;
        observe(0, cur_row, 16'h0);
      end
      if (dq_oe && !oe_n) bus_err++;
      dq_in = (!ras_n && !cas_n && !oe_n && we_n && col_done) ? rdata : 16'hDEAD;
      pr_ras = ras_n;
      pr_cas = cas_n;
    end
  end

  task automatic run_test(input int f, input bit poke, input int e_fail, input int e_row,
                          input int e_phase, input int e_pass);
    int c;
    model_reset(f);
    build_expect();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    c = 0;
    while (!done && c < 30000) begin
      @(negedge clk);
      c++;
      if (poke && (c == 3000 || c == 20000)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done, "R8 done raised", done, 1);
    chk(sbq.size() == 0, "R7 all expected cycles seen", sbq.size(), 0);
    chk(ror_cnt == 8, "R10 R2 row-only cycle count", ror_cnt, 8);
    chk(col_err == 0, "R4 column address", col_err, 0);
    chk(bus_err == 0, "R11 data drive overlap", bus_err, 0);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe, "R8 strobes idle at done",
        {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
    chk(fail == e_fail[0], "R9 fail flag", fail, e_fail);
    chk(pass == (done && !e_fail[0]), "R8 pass flag", pass, !e_fail[0]);
    if (e_fail != 0) begin
      chk(fail_row == e_row[8:0], "R9 fail row", fail_row, e_row);
      chk(fail_phase == e_phase[1:0], "R9 fail phase", fail_phase, e_phase);
      chk(fail_pass == e_pass[0], "R9 fail pass", fail_pass, e_pass);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!dq_oe && !done && !pass && !fail, "R1 idle outputs", {dq_oe, done, pass, fail}, 0);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high before start", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    run_test(0, 1, 0, 0, 0, 0);
    run_test(1, 0, 1, 37, 2, 0);
    run_test(3, 0, 1, 200, 1, 1);
    run_test(2, 0, 1, 0, 1, 0);
    run_test(0, 0, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule